// File: doc/BRIEF.md
# PWM Channel Gate and Interrupt Register Block

This block holds the shared control registers of a multi-channel PWM peripheral, one bit per channel. Software starts and stops channels through a pair of strobe registers (a one sets, a one clears, a zero leaves the bit alone). It reads back the running set from a status register. The interrupt mask is handled with a second strobe pair. A mode word is stored for the clock dividers that sit outside the block, and it drives them through a port.

Each channel counter pulses an end-of-period event into the block. Events are latched into sticky pending bits. A read of the pending register returns them and acknowledges them in the same access. A single interrupt line is raised whenever a pending bit meets a set mask bit. Bus accesses are single-cycle: writes take effect at the clock edge, read data is combinational from the current register state.

Top module: `pwm_gate_irq`

## Requirements
- R1: After reset the channel enables, interrupt mask, pending events, mode word and interrupt line are all zero.
- R2: Offset 0x00 is a read/write mode word of DATA_W bits, presented unchanged on `mode_o` from the cycle after the write.
- R3: Writing to offset 0x04 sets every channel enable whose data bit n is 1; bits written as 0 leave their channel as it was.
- R4: Writing to offset 0x08 clears every channel enable whose data bit n is 1; bits written as 0 leave their channel as it was.
- R5: A read of offset 0x0C returns the channel enables in bits NUM_CH-1:0, equal to `ch_en_o`.
- R6: Writing ones to offset 0x10 sets mask bits, writing ones to offset 0x14 clears them, and offset 0x18 reads back the mask; the mask changes only through these two offsets.
- R7: A pulse on `period_evt_i[n]` sets pending bit n, which stays set until a read of offset 0x1C; that read returns the pending bits and clears them at the same edge.
- R8: An event arriving in the same cycle as a read of offset 0x1C is not lost: it is pending after that read, and is returned by the following one.
- R9: `irq_o` is high in exactly the cycles where some channel has both its pending bit and its mask bit set.
- R10: Writes to offsets 0x0C, 0x18 and 0x1C change nothing, reads of any offset other than 0x1C leave pending bits alone, and bits at or above NUM_CH of every per-channel register read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid while req_i is high with we_i low |
| period_evt_i | input | NUM_CH | End-of-period pulses from the channel counters |
| ch_en_o | output | NUM_CH | Run enables to the channel counters |
| mode_o | output | DATA_W | Mode word to the clock dividers |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong enable bit shows on `ch_en_o` in the very cycle after the faulty strobe write, and a lost or stale pending bit shows on the next read of the pending register and on `irq_o` as soon as the mask admits that channel. Because reads acknowledge, a clear that fires at the wrong time is visible as a missing bit in the following read. A mask that drifts is exposed by the mask readback and by `irq_o` rising or falling one edge off the expected cycle.

// File: rtl/pwm_gate_irq_pkg.sv
package pwm_gate_irq_pkg;
  localparam int ADDR_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    REG_MODE   = 5'h00,
    REG_RUN    = 5'h04,
    REG_HALT   = 5'h08,
    REG_ACTIVE = 5'h0C,
    REG_IRQ_ON = 5'h10,
    REG_IRQ_OFF= 5'h14,
    REG_IRQ_MSK= 5'h18,
    REG_PEND   = 5'h1C
  } reg_e;
endpackage

// File: rtl/pwm_setclr_bank.sv
module pwm_setclr_bank #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= (q_q | set_i) & ~clr_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/pwm_evt_latch.sv
module pwm_evt_latch #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         ack_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] pend_q;

  // new events win over the acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (ack_i ? '0 : pend_q) | evt_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/pwm_gate_irq.sv
module pwm_gate_irq
  import pwm_gate_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_CH-1:0] period_evt_i,
  output logic [NUM_CH-1:0] ch_en_o,
  output logic [DATA_W-1:0] mode_o,
  output logic              irq_o
);
  logic              wr, rd;
  logic [NUM_CH-1:0] wd_ch;
  logic [NUM_CH-1:0] run_set, run_clr, msk_set, msk_clr;
  logic [NUM_CH-1:0] en_q, mask_q, pend_q;
  logic              ack;
  logic [DATA_W-1:0] mode_q;

  assign wr    = req_i & we_i;
  assign rd    = req_i & ~we_i;
  assign wd_ch = wdata_i[NUM_CH-1:0];

  assign run_set = (wr && addr_i == REG_RUN)     ? wd_ch : '0;
  assign run_clr = (wr && addr_i == REG_HALT)    ? wd_ch : '0;
  assign msk_set = (wr && addr_i == REG_IRQ_ON)  ? wd_ch : '0;
  assign msk_clr = (wr && addr_i == REG_IRQ_OFF) ? wd_ch : '0;
  assign ack     = rd && addr_i == REG_PEND;

  pwm_setclr_bank #(.W(NUM_CH)) u_run (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(run_set), .clr_i(run_clr), .q_o(en_q)
  );

  pwm_setclr_bank #(.W(NUM_CH)) u_msk (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(msk_set), .clr_i(msk_clr), .q_o(mask_q)
  );

  pwm_evt_latch #(.W(NUM_CH)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(period_evt_i), .ack_i(ack), .pend_o(pend_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       mode_q <= '0;
    else if (wr && addr_i == REG_MODE) mode_q <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (addr_i)
        REG_MODE:    rdata_o = mode_q;
        REG_ACTIVE:  rdata_o[NUM_CH-1:0] = en_q;
        REG_IRQ_MSK: rdata_o[NUM_CH-1:0] = mask_q;
        REG_PEND:    rdata_o[NUM_CH-1:0] = pend_q;
        default:     rdata_o = '0;
      endcase
    end
  end

  assign ch_en_o = en_q;
  assign mode_o  = mode_q;
  assign irq_o   = |(pend_q & mask_q);
endmodule

// File: rtl/pwm_gate_irq_chk.sv
module pwm_gate_irq_chk
  import pwm_gate_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [NUM_CH-1:0] period_evt_i,
  input logic [NUM_CH-1:0] ch_en_o,
  input logic              irq_o,
  input logic [NUM_CH-1:0] mask_q,
  input logic [NUM_CH-1:0] pend_q
);
  logic wr_run, wr_halt, wr_msk, wr_pend_clean;
  assign wr_run  = req_i && we_i && addr_i == REG_RUN;
  assign wr_halt = req_i && we_i && addr_i == REG_HALT;
  assign wr_msk  = req_i && we_i && (addr_i == REG_IRQ_ON || addr_i == REG_IRQ_OFF);
  assign wr_pend_clean = req_i && !we_i && addr_i == REG_PEND && period_evt_i == '0;

  p_run_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_run |=> ((ch_en_o & $past(wdata_i[NUM_CH-1:0])) == $past(wdata_i[NUM_CH-1:0])));

  p_halt_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_halt |=> ((ch_en_o & $past(wdata_i[NUM_CH-1:0])) == '0));

  p_en_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_run || wr_halt) |=> $stable(ch_en_o));

  p_mask_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_msk |=> $stable(mask_q));

  p_ack_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pend_clean |=> (pend_q == '0));

  p_evt_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_evt_i != '0) |=> ((pend_q & $past(period_evt_i)) == $past(period_evt_i)));

  p_irq_needs_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);
endmodule

bind pwm_gate_irq pwm_gate_irq_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .period_evt_i(period_evt_i), .ch_en_o(ch_en_o), .irq_o(irq_o),
  .mask_q(mask_q), .pend_q(pend_q)
);

// File: tb/pwm_gate_irq_tb.sv
`timescale 1ns/1ps
module pwm_gate_irq_tb;
  localparam int NUM_CH = 4;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic        rq;
    logic        we;
    logic [4:0]  addr;
    logic [31:0] data;
    logic [3:0]  evt;
    logic [31:0] exp_rd;
    logic [3:0]  exp_en;
    logic        exp_irq;
    logic [3:0]  req_no;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b1,5'h04,32'h5,      4'h0,32'h0,      4'h5,1'b0,4'd3},  // R3
    '{1'b1,1'b1,5'h04,32'h2,      4'h0,32'h0,      4'h7,1'b0,4'd3},  // R3 zeros kept
    '{1'b1,1'b1,5'h08,32'h4,      4'h0,32'h0,      4'h3,1'b0,4'd4},  // R4
    '{1'b1,1'b0,5'h0C,32'h0,      4'h0,32'h3,      4'h3,1'b0,4'd5},  // R5
    '{1'b1,1'b1,5'h00,32'h30A07,  4'h0,32'h0,      4'h3,1'b0,4'd2},  // R2
    '{1'b1,1'b0,5'h00,32'h0,      4'h0,32'h30A07,  4'h3,1'b0,4'd2},  // R2
    '{1'b0,1'b0,5'h00,32'h0,      4'h2,32'h0,      4'h3,1'b0,4'd9},  // R9 unmasked
    '{1'b1,1'b1,5'h10,32'h2,      4'h0,32'h0,      4'h3,1'b1,4'd9},  // R9
    '{1'b1,1'b0,5'h18,32'h0,      4'h0,32'h2,      4'h3,1'b1,4'd6},  // R6
    '{1'b1,1'b0,5'h1C,32'h0,      4'h1,32'h2,      4'h3,1'b0,4'd8},  // R8
    '{1'b1,1'b1,5'h10,32'h1,      4'h0,32'h0,      4'h3,1'b1,4'd6},  // R6
    '{1'b1,1'b1,5'h14,32'h1,      4'h0,32'h0,      4'h3,1'b0,4'd6},  // R6
    '{1'b1,1'b0,5'h1C,32'h0,      4'h0,32'h1,      4'h3,1'b0,4'd8},  // R8
    '{1'b1,1'b0,5'h1C,32'h0,      4'h0,32'h0,      4'h3,1'b0,4'd7},  // R7
    '{1'b0,1'b0,5'h00,32'h0,      4'hF,32'h0,      4'h3,1'b1,4'd7},  // R7
    '{1'b1,1'b1,5'h1C,32'hF,      4'h0,32'h0,      4'h3,1'b1,4'd10}, // R10
    '{1'b1,1'b0,5'h18,32'h0,      4'h0,32'h2,      4'h3,1'b1,4'd10}, // R10
    '{1'b1,1'b0,5'h1C,32'h0,      4'h0,32'hF,      4'h3,1'b0,4'd7}   // R7
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0, we_i = 1'b0;
  logic [4:0]        addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o;
  logic [NUM_CH-1:0] period_evt_i = '0;
  logic [NUM_CH-1:0] ch_en_o;
  logic [DATA_W-1:0] mode_o;
  logic              irq_o;

  int checks = 0, errors = 0;

  always #2.5 clk_i = ~clk_i;

  pwm_gate_irq #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .period_evt_i(period_evt_i),
    .ch_en_o(ch_en_o), .mode_o(mode_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [4:0] a, input logic [31:0] d,
                        input logic [3:0] e, output logic [31:0] rd);
    @(negedge clk_i);
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d; period_evt_i = e;
    #1 rd = rdata_o;
    @(posedge clk_i);
    #1;
    req_i = 1'b0; we_i = 1'b0; period_evt_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk_i);
    #1;
    // R1 reset state at the ports
    check("R1 ch_en", {28'h0, ch_en_o}, 32'h0);
    check("R1 irq", {31'h0, irq_o}, 32'h0);
    check("R1 mode", mode_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    access(1'b0, 5'h18, 32'h0, 4'h0, r);
    check("R1 mask", r, 32'h0);
    access(1'b0, 5'h1C, 32'h0, 4'h0, r);
    check("R1 pending", r, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      req_i = VEC[i].rq; we_i = VEC[i].we; addr_i = VEC[i].addr;
      wdata_i = VEC[i].data; period_evt_i = VEC[i].evt;
      #1;
      if (VEC[i].rq && !VEC[i].we)
        check($sformatf("R%0d read vec %0d", VEC[i].req_no, i), rdata_o, VEC[i].exp_rd);
      @(posedge clk_i);
      #1;
      req_i = 1'b0; we_i = 1'b0; period_evt_i = '0;
      check($sformatf("R%0d en vec %0d", VEC[i].req_no, i), {28'h0, ch_en_o}, {28'h0, VEC[i].exp_en});
      check($sformatf("R%0d irq vec %0d", VEC[i].req_no, i), {31'h0, irq_o}, {31'h0, VEC[i].exp_irq});
    end

    // R2 mode word reaches the divider port
    check("R2 mode_o", mode_o, 32'h30A07);
    // R10 upper bits ignored on write and read as zero
    access(1'b1, 5'h04, 32'hFFFF_FFFF, 4'h0, r);
    access(1'b0, 5'h0C, 32'h0, 4'h0, r);
    check("R10 upper bits zero", r, 32'hF);
    // R10 write to status has no effect
    access(1'b1, 5'h0C, 32'h0, 4'h0, r);
    check("R10 status write ignored", {28'h0, ch_en_o}, 32'hF);
    // R10 other reads leave pending alone
    access(1'b0, 5'h00, 32'h0, 4'h4, r);
    access(1'b0, 5'h0C, 32'h0, 4'h0, r);
    check("R10 pending kept irq", {31'h0, irq_o}, 32'h0);
    access(1'b0, 5'h1C, 32'h0, 4'h0, r);
    check("R10 pending kept", r, 32'h4);
    // R4 clear all at once
    access(1'b1, 5'h08, 32'hFFFF_FFFF, 4'h0, r);
    check("R4 all off", {28'h0, ch_en_o}, 32'h0);
    // R9 mask set before the event
    access(1'b1, 5'h10, 32'h8, 4'h0, r);
    check("R9 no event", {31'h0, irq_o}, 32'h0);
    access(1'b0, 5'h00, 32'h0, 4'h8, r);
    check("R9 event raises", {31'h0, irq_o}, 32'h1);
    access(1'b0, 5'h1C, 32'h0, 4'h0, r);
    check("R7 ack read", r, 32'h8);
    check("R9 drops after ack", {31'h0, irq_o}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule